// File: doc/BRIEF.md
# Control-Transfer Next-PC Unit

This block works out where execution goes next after a control-transfer instruction in a 32-bit integer core. It is purely combinational. The decoder supplies the current program counter, two compare operands, a base register value, an offset that is already sign-extended, and a transfer kind. The unit evaluates one of six branch conditions, forms the jump or branch target, and returns three results: the next program counter, a flag that says whether the transfer was taken, and the return address that a jump-and-link writes back.

Both direct jumps and conditional branches count their offsets in half-words, so the unit doubles the offset before it adds it to the PC. The register-indirect jump adds a byte offset to the base value and clears bit 0 of the sum. Every addition wraps modulo 2^32. When no transfer is requested, or a branch condition fails, execution falls through to PC + 4.

Top module: `xfer_target_unit`

## Requirements
- R1: `kind_i` is decoded as 0 = none, 1 = direct jump, 2 = register jump, 3 = branch-if-equal, 4 = branch-if-not-equal, 5 = signed less-than, 6 = signed greater-or-equal, 7 = unsigned less-than, 8 = unsigned greater-or-equal. Codes 9 to 15 act exactly like code 0.
- R2: For a direct jump, `taken_o` is 1 and `next_pc_o` equals `pc_i + 2*offset_i`.
- R3: For a register jump, `taken_o` is 1 and `next_pc_o` equals `base_i + offset_i` with bit 0 forced to 0.
- R4: `link_o` always equals `pc_i + 4`, whatever the kind.
- R5: The equal and not-equal conditions compare all 32 bits of `rs_a_i` and `rs_b_i`. Each is the exact complement of the other.
- R6: The signed conditions treat both operands as two's complement, so 0x80000000 is below 0x7FFFFFFF. Greater-or-equal is true when the operands are equal.
- R7: The unsigned conditions treat both operands as unsigned, so 0x7FFFFFFF is below 0x80000000. Greater-or-equal is true when the operands are equal.
- R8: When a branch condition holds, `taken_o` is 1 and `next_pc_o` equals `pc_i + 2*offset_i`. When it fails, `taken_o` is 0 and `next_pc_o` equals `pc_i + 4`.
- R9: For kind 0 and codes 9 to 15, `taken_o` is 0 and `next_pc_o` equals `pc_i + 4`.
- R10: All target and sequential additions wrap modulo 2^32. For example, PC 0xFFFFFFFC gives a sequential address of 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the current instruction |
| rs_a_i | input | 32 | First compare operand |
| rs_b_i | input | 32 | Second compare operand |
| base_i | input | 32 | Base value for the register jump |
| offset_i | input | 32 | Sign-extended offset: half-words for jumps and branches, bytes for the register jump |
| kind_i | input | 4 | Transfer kind, encoded as in R1 |
| next_pc_o | output | 32 | Address of the next instruction |
| taken_o | output | 1 | 1 when control leaves the sequential path |
| link_o | output | 32 | Return address for write-back |

## Verification
The block holds no state, so any fault appears at the ports in the same evaluation as the inputs that trigger it. No error can hide for a cycle and surface later. A wrong comparator shows up as a `taken_o` value that disagrees with the signed or unsigned order of the operands, most visibly at the 0x7FFFFFFF/0x80000000 boundary and on equal operands. A wrong target path shows up as a `next_pc_o` that is off by the missing doubling, has bit 0 left set, or is missing its wraparound.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int KIND_W = 4;

  typedef enum logic [KIND_W-1:0] {
    XK_NONE = 4'd0,
    XK_JMP  = 4'd1,
    XK_RJMP = 4'd2,
    XK_EQ   = 4'd3,
    XK_NE   = 4'd4,
    XK_SLT  = 4'd5,
    XK_SGE  = 4'd6,
    XK_ULT  = 4'd7,
    XK_UGE  = 4'd8
  } xfer_kind_e;

  typedef struct packed {
    logic is_jmp;
    logic is_rjmp;
    logic is_cond;
  } xfer_class_t;
endpackage

// File: rtl/xfer_cond_eval.sv
module xfer_cond_eval #(
  parameter int XLEN      = 32,
  parameter int CMP_STYLE = 1
) (
  input  logic [XLEN-1:0]            op_a,
  input  logic [XLEN-1:0]            op_b,
  input  logic [xfer_pkg::KIND_W-1:0] kind,
  output logic                       cond_met
);
  import xfer_pkg::*;

  logic is_eq;
  logic is_ltu;
  logic is_lts;

  assign is_eq = (op_a == op_b);

  generate
    if (CMP_STYLE == 0) begin : g_native
      assign is_ltu = (op_a < op_b);
      assign is_lts = ($signed(op_a) < $signed(op_b));
    end else begin : g_borrow
      logic [XLEN:0] diff;
      assign diff   = {1'b0, op_a} - {1'b0, op_b};
      assign is_ltu = diff[XLEN];
      assign is_lts = (op_a[XLEN-1] ^ op_b[XLEN-1]) ? op_a[XLEN-1] : diff[XLEN];
    end
  endgenerate

  always_comb begin
    unique case (kind)
      XK_EQ:   cond_met = is_eq;
      XK_NE:   cond_met = ~is_eq;
      XK_SLT:  cond_met = is_lts;
      XK_SGE:  cond_met = ~is_lts;
      XK_ULT:  cond_met = is_ltu;
      XK_UGE:  cond_met = ~is_ltu;
      default: cond_met = 1'b0;
    endcase
  end
endmodule

// File: rtl/xfer_target_calc.sv
module xfer_target_calc #(
  parameter int XLEN       = 32,
  parameter int STEP_BYTES = 4
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] offset,
  output logic [XLEN-1:0] seq_addr,
  output logic [XLEN-1:0] rel_addr,
  output logic [XLEN-1:0] reg_addr
);
  localparam logic [XLEN-1:0] STEP = XLEN'(STEP_BYTES);

  function automatic logic [XLEN-1:0] half_word_rel(input logic [XLEN-1:0] p,
                                                    input logic [XLEN-1:0] o);
    return p + {o[XLEN-2:0], 1'b0};
  endfunction

  function automatic logic [XLEN-1:0] even_sum(input logic [XLEN-1:0] b,
                                               input logic [XLEN-1:0] o);
    logic [XLEN-1:0] s;
    s = b + o;
    return {s[XLEN-1:1], 1'b0};
  endfunction

  assign seq_addr = pc + STEP;
  assign rel_addr = half_word_rel(pc, offset);
  assign reg_addr = even_sum(base, offset);
endmodule

// File: rtl/xfer_target_unit.sv
module xfer_target_unit #(
  parameter int XLEN      = 32,
  parameter int CMP_STYLE = 1
) (
  input  logic [31:0] pc_i,
  input  logic [31:0] rs_a_i,
  input  logic [31:0] rs_b_i,
  input  logic [31:0] base_i,
  input  logic [31:0] offset_i,
  input  logic [3:0]  kind_i,
  output logic [31:0] next_pc_o,
  output logic        taken_o,
  output logic [31:0] link_o
);
  import xfer_pkg::*;

  xfer_class_t     cls;
  logic            cond_met;
  logic [XLEN-1:0] seq_addr;
  logic [XLEN-1:0] rel_addr;
  logic [XLEN-1:0] reg_addr;

  always_comb begin
    cls.is_jmp  = (kind_i == XK_JMP);
    cls.is_rjmp = (kind_i == XK_RJMP);
    cls.is_cond = (kind_i >= XK_EQ) && (kind_i <= XK_UGE);
  end

  xfer_cond_eval #(.XLEN(XLEN), .CMP_STYLE(CMP_STYLE)) u_cond (
    .op_a     (rs_a_i),
    .op_b     (rs_b_i),
    .kind     (kind_i),
    .cond_met (cond_met)
  );

  xfer_target_calc #(.XLEN(XLEN), .STEP_BYTES(4)) u_tgt (
    .pc       (pc_i),
    .base     (base_i),
    .offset   (offset_i),
    .seq_addr (seq_addr),
    .rel_addr (rel_addr),
    .reg_addr (reg_addr)
  );

  always_comb begin
    taken_o = cls.is_jmp | cls.is_rjmp | (cls.is_cond & cond_met);
    if (!taken_o)         next_pc_o = seq_addr;
    else if (cls.is_rjmp) next_pc_o = reg_addr;
    else                  next_pc_o = rel_addr;
  end

  assign link_o = seq_addr;
endmodule

// File: rtl/xfer_target_unit_chk.sv
module xfer_target_unit_chk (
  input logic [31:0] pc_i,
  input logic [31:0] rs_a_i,
  input logic [31:0] rs_b_i,
  input logic [31:0] base_i,
  input logic [31:0] offset_i,
  input logic [3:0]  kind_i,
  input logic [31:0] next_pc_o,
  input logic        taken_o,
  input logic [31:0] link_o,
  input logic        cond_met
);
  always_comb begin
    if (kind_i == 4'd1 || kind_i == 4'd2) AST_JUMP_TAKEN: assert (taken_o); // R2
    if (kind_i == 4'd2) AST_RJMP_EVEN: assert (next_pc_o[0] == 1'b0); // R3
    AST_LINK_SEQ: assert (link_o == pc_i + 32'd4); // R4
    if (!taken_o) AST_FALLTHRU_SEQ: assert (next_pc_o == link_o); // R8
    if (kind_i == 4'd0 || kind_i > 4'd8) AST_IDLE_NOT_TAKEN: assert (!taken_o); // R9
    if (kind_i >= 4'd3 && kind_i <= 4'd8) AST_COND_DRIVES_TAKEN: assert (taken_o == cond_met); // R8
    if (kind_i == 4'd3) AST_EQ_MATCH: assert (cond_met == (rs_a_i == rs_b_i)); // R5
  end
endmodule

bind xfer_target_unit xfer_target_unit_chk u_chk (
  .pc_i      (pc_i),
  .rs_a_i    (rs_a_i),
  .rs_b_i    (rs_b_i),
  .base_i    (base_i),
  .offset_i  (offset_i),
  .kind_i    (kind_i),
  .next_pc_o (next_pc_o),
  .taken_o   (taken_o),
  .link_o    (link_o),
  .cond_met  (cond_met)
);

// File: tb/xfer_target_unit_bench.sv
module xfer_target_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc, ra, rb, base, off;
  logic [3:0]  kind;
  logic [31:0] next_pc, link;
  logic        taken;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  xfer_target_unit u_xfer_target_unit (
    .pc_i(pc), .rs_a_i(ra), .rs_b_i(rb), .base_i(base), .offset_i(off),
    .kind_i(kind), .next_pc_o(next_pc), .taken_o(taken), .link_o(link)
  );

  // Bench model: signed order via sign-bit flip, unsigned order via 33-bit compare
  function automatic bit m_ltu(input logic [31:0] a, input logic [31:0] b);
    return {1'b0, a} < {1'b0, b};
  endfunction
  function automatic bit m_lts(input logic [31:0] a, input logic [31:0] b);
    return m_ltu(a ^ 32'h8000_0000, b ^ 32'h8000_0000);
  endfunction
  function automatic bit m_cond(input logic [3:0] k, input logic [31:0] a, input logic [31:0] b);
    case (k)
      4'd3: return a == b;
      4'd4: return a != b;
      4'd5: return m_lts(a, b);
      4'd6: return !m_lts(a, b);
      4'd7: return m_ltu(a, b);
      4'd8: return !m_ltu(a, b);
      default: return 1'b0;
    endcase
  endfunction
  function automatic bit m_taken(input logic [3:0] k, input logic [31:0] a, input logic [31:0] b);
    return (k == 4'd1) || (k == 4'd2) || m_cond(k, a, b);
  endfunction
  function automatic logic [31:0] m_next(input logic [3:0] k, input logic [31:0] p,
      input logic [31:0] a, input logic [31:0] b, input logic [31:0] bs, input logic [31:0] o);
    logic [63:0] wide;
    if (!m_taken(k, a, b)) begin
      wide = 64'(p) + 64'd4;
    end else if (k == 4'd2) begin
      wide = 64'(bs) + 64'(o);
      wide[0] = 1'b0;
    end else begin
      wide = 64'(p) + 64'(o) * 64'd2;
    end
    return wide[31:0];
  endfunction

  function automatic string req_of(input logic [3:0] k);
    case (k)
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3, 4'd4: return "R5";
      4'd5, 4'd6: return "R6";
      4'd7, 4'd8: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(input logic [3:0] k, input logic [31:0] p, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] bs, input logic [31:0] o,
                       input string tag);
    logic [31:0] exp_n, exp_l;
    bit exp_t;
    @(negedge clk);
    kind = k; pc = p; ra = a; rb = b; base = bs; off = o;
    #1;
    exp_t = m_taken(k, a, b);
    exp_n = m_next(k, p, a, b, bs, o);
    exp_l = p + 32'd4;
    checks++;
    if (taken !== exp_t) begin
      errors++;
      $display("FAIL %s taken kind=%0d actual=%0b expected=%0b", tag, k, taken, exp_t);
    end
    checks++;
    if (next_pc !== exp_n) begin
      errors++;
      $display("FAIL %s next_pc kind=%0d actual=%08h expected=%08h", tag, k, next_pc, exp_n);
    end
    checks++;
    if (link !== exp_l) begin
      errors++;
      $display("FAIL R4 link actual=%08h expected=%08h", link, exp_l);
    end
  endtask

  function automatic logic [31:0] pick_val();
    case ($urandom_range(0, 7))
      0: return 32'h8000_0000;
      1: return 32'h7FFF_FFFF;
      2: return 32'hFFFF_FFFF;
      3: return 32'h0000_0000;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    kind = 4'd0; pc = 32'h1000; ra = '0; rb = '0; base = '0; off = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    // reset-state check with idle kind (R9)
    apply(4'd0, 32'h0000_1000, 0, 0, 0, 0, "R9");
    rst_n = 1'b1;
    // R1: unused codes behave as none
    for (int k = 9; k < 16; k++) apply(4'(k), 32'h2000, 5, 5, 32'h11, 32'h40, "R1");
    // R2 / R10: direct jump, negative offset and wrap
    apply(4'd1, 32'h0000_0100, 0, 0, 0, 32'hFFFF_FFF0, "R2");
    apply(4'd1, 32'hFFFF_FFFC, 0, 0, 0, 32'h0000_0004, "R10");
    apply(4'd0, 32'hFFFF_FFFC, 0, 0, 0, 0, "R10");
    // R3: odd sum is cleared
    apply(4'd2, 32'h500, 0, 0, 32'h0000_1001, 32'h0000_0002, "R3");
    apply(4'd2, 32'h500, 0, 0, 32'h0000_0010, 32'hFFFF_FFFF, "R3");
    // R5 equal / not equal
    apply(4'd3, 32'h40, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 0, 32'h8, "R5");
    apply(4'd4, 32'h40, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 0, 32'h8, "R5");
    apply(4'd3, 32'h40, 32'h0000_0001, 32'h8000_0001, 0, 32'h8, "R5");
    // R6 signed boundary
    apply(4'd5, 32'h80, 32'h8000_0000, 32'h7FFF_FFFF, 0, 32'h10, "R6");
    apply(4'd6, 32'h80, 32'h8000_0000, 32'h7FFF_FFFF, 0, 32'h10, "R6");
    apply(4'd6, 32'h80, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 32'h10, "R6");
    // R7 unsigned boundary
    apply(4'd7, 32'h80, 32'h8000_0000, 32'h7FFF_FFFF, 0, 32'h10, "R7");
    apply(4'd8, 32'h80, 32'h7FFF_FFFF, 32'h8000_0000, 0, 32'h10, "R7");
    apply(4'd8, 32'h80, 32'h0, 32'h0, 0, 32'h10, "R7");
    // R8 branch taken backwards with wrap, and failing branch
    apply(4'd4, 32'h0000_0008, 1, 2, 0, 32'hFFFF_FFF8, "R8");
    apply(4'd7, 32'h0000_0008, 2, 1, 0, 32'hFFFF_FFF8, "R8");
    // random stimulus
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] k;
      logic [31:0] a, b;
      k = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(9, 15)) : 4'($urandom_range(0, 8));
      a = pick_val();
      b = ($urandom_range(0, 3) == 0) ? a : pick_val();
      apply(k, $urandom, a, b, $urandom, pick_val(), req_of(k));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule